// File: doc/BRIEF.md
# PCI Bus-Master Burst DMA Engine

This block is the initiator half of a 32-bit PCI-style bus interface. Software programs a bus-side start address, a local memory start address and a control word that holds a transfer count and a direction. Setting the start bit makes the engine request the bus. Once the grant is seen and the bus is idle, it drives one address phase and then a run of data phases, counting each completed phase against the programmed count.

The engine inserts its own wait states by holding IRDY# high while the local backend is not ready. It ends the burst itself by raising FRAME# together with the IRDY# of the final data phase. After one turnaround cycle it stops driving the bus. A target STOP# cuts the burst short and leaves an abort flag set. Done and abort are sticky until software clears them.

Top module: `dma_burst_master`

## Requirements
- R1: Register index 0 holds the bus start address and index 1 holds the local start address. Both read back what was written. While a burst is in progress, writes to indexes 0 and 1 and to the count/direction fields are ignored.
- R2: The control word is at index 2. It has count in bits [15:0], direction in bit 16 (1 = write to the bus), start/busy in bit 17, done in bit 18 and abort in bit 19. Writing bit 17 high with a nonzero count while idle drives REQ# low from the next cycle. Writing it high with a zero count is ignored.
- R3: The address phase starts only on the edge after a cycle in which GNT# is low and both observed FRAME# and IRDY# are high. It never starts while the grant is missing or the bus is busy.
- R4: During the address phase the engine drives FRAME# low, the bus start address on AD and command 0111 (write) or 0110 (read) on C/BE#. During write data phases it drives the backend write data on AD.
- R5: A data phase completes in any cycle where IRDY# and TRDY# are both low. Each completed phase is signalled to the backend, decrements the count, and advances both addresses by 4.
- R6: IRDY# stays high while the backend is not ready. Once IRDY# is low, it stays low until TRDY# completes the phase or STOP# is seen.
- R7: FRAME# goes high in the same cycle IRDY# goes low for the final counted data phase. It is low for every earlier data phase.
- R8: After the final phase, FRAME# and IRDY# are driven high for one cycle. Then all bus drivers turn off, REQ# is high, busy reads 0, done reads 1 and the count reads 0.
- R9: Done and abort stay set until a control write with that bit at 1 clears them. A new start also clears them.
- R10: STOP# low during a data phase ends the burst after that cycle and sets abort. Done stays clear, and the count shows the phases that did not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n_in | input | 1 | Observed FRAME# |
| irdy_n_in | input | 1 | Observed IRDY# |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| frame_n_out | output | 1 | Driven FRAME# value |
| frame_oe | output | 1 | FRAME# driver enable |
| irdy_n_out | output | 1 | Driven IRDY# value |
| irdy_oe | output | 1 | IRDY# driver enable |
| ad_out | output | 32 | Address/data driven value |
| ad_oe | output | 1 | AD driver enable |
| cbe_n_out | output | 4 | Command / byte enables |
| be_ready | input | 1 | Backend ready for a data phase |
| be_wdata | input | 32 | Backend write data |
| be_xfer | output | 1 | Data phase completes at the next edge |
| ram_addr | output | 32 | Current local address |

## Verification
REQ# is due one edge after the start write. The address phase is due one edge after the first cycle with the grant present and the bus idle. IRDY#, FRAME# on the last phase, and the backend strobe are combinational within the data cycle, so they are read mid-cycle in that same cycle. Address, count, done and abort change at the edge that closes a completed phase. The driver pushes one expected local address per data phase into a queue. A monitor pops one entry at each strobe, sampled on the falling edge, and compares the address and the FRAME# level. Mid-cycle probes check the no-grant, busy-bus and register-lockout windows, the first two IRDY# values and the readback after the burst.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } dma_state_e;

  localparam logic [1:0] RIX_BUS  = 2'd0;
  localparam logic [1:0] RIX_LOC  = 2'd1;
  localparam logic [1:0] RIX_CTRL = 2'd2;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_burst_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [AW-1:0] wdata,
  input  logic          busy,
  input  logic          step,
  input  logic          fin_ok,
  input  logic          fin_abort,
  output logic          start_go,
  output logic [AW-1:0] bus_addr,
  output logic [AW-1:0] loc_addr,
  output logic [CW-1:0] count,
  output logic          dir_wr,
  output logic [AW-1:0] rdata
);
  localparam int DIR_B  = CW;
  localparam int GO_B   = CW + 1;
  localparam int DONE_B = CW + 2;
  localparam int ABT_B  = CW + 3;
  localparam logic [AW-1:0] ADDR_STEP = AW'(4);

  logic [AW-1:0] bus_q, bus_d, loc_q, loc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d, done_q, done_d, abt_q, abt_d;
  logic          bus_en, loc_en, cnt_en, ctrl_wr;

  assign ctrl_wr  = wr_en && (addr == RIX_CTRL);
  assign start_go = ctrl_wr && !busy && wdata[GO_B] && (wdata[CW-1:0] != '0);

  always_comb begin
    bus_en = (wr_en && (addr == RIX_BUS) && !busy) || step;
    loc_en = (wr_en && (addr == RIX_LOC) && !busy) || step;
    cnt_en = (ctrl_wr && !busy) || step;
    bus_d  = step ? bus_q + ADDR_STEP : wdata;
    loc_d  = step ? loc_q + ADDR_STEP : wdata;
    cnt_d  = step ? cnt_q - CW'(1) : wdata[CW-1:0];
    dir_d  = (ctrl_wr && !busy) ? wdata[DIR_B] : dir_q;
    done_d = done_q;
    if (start_go)                   done_d = 1'b0;
    else if (fin_ok)                done_d = 1'b1;
    else if (ctrl_wr && wdata[DONE_B]) done_d = 1'b0;
    abt_d = abt_q;
    if (start_go)                   abt_d = 1'b0;
    else if (fin_abort)             abt_d = 1'b1;
    else if (ctrl_wr && wdata[ABT_B]) abt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= '0;
      loc_q  <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      if (bus_en) bus_q <= bus_d;
      if (loc_en) loc_q <= loc_d;
      if (cnt_en) cnt_q <= cnt_d;
      dir_q  <= dir_d;
      done_q <= done_d;
      abt_q  <= abt_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RIX_BUS: rdata = bus_q;
      RIX_LOC: rdata = loc_q;
      RIX_CTRL: begin
        rdata[CW-1:0] = cnt_q;
        rdata[DIR_B]  = dir_q;
        rdata[GO_B]   = busy;
        rdata[DONE_B] = done_q;
        rdata[ABT_B]  = abt_q;
      end
      default: rdata = '0;
    endcase
  end

  assign bus_addr = bus_q;
  assign loc_addr = loc_q;
  assign count    = cnt_q;
  assign dir_wr   = dir_q;
endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
  import dma_burst_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  logic          last,
  input  logic          dir_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] be_wdata,
  input  logic          gnt_n,
  input  logic          frame_n_in,
  input  logic          irdy_n_in,
  input  logic          trdy_n,
  input  logic          stop_n,
  input  logic          be_ready,
  output logic          busy,
  output logic          step,
  output logic          fin_ok,
  output logic          fin_abort,
  output logic          req_n,
  output logic          frame_n_out,
  output logic          frame_oe,
  output logic          irdy_n_out,
  output logic          irdy_oe,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic [3:0]    cbe_n_out
);
  dma_state_e st_q, st_d;
  logic hold_q, hold_d;
  logic in_addr, in_data, irdy_act, xfer;

  assign in_addr  = (st_q == ST_ADDR);
  assign in_data  = (st_q == ST_DATA);
  assign irdy_act = in_data && (be_ready || hold_q);
  assign xfer     = irdy_act && !trdy_n;
  assign hold_d   = irdy_act && trdy_n && stop_n;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_go) st_d = ST_REQ;
      ST_REQ:  if (!gnt_n && frame_n_in && irdy_n_in) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: if ((xfer && last) || !stop_n) st_d = ST_TURN;
      ST_TURN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    busy        = (st_q != ST_IDLE);
    step        = xfer;
    fin_ok      = xfer && last;
    fin_abort   = in_data && !stop_n && !(xfer && last);
    req_n       = (st_q != ST_REQ);
    frame_oe    = in_addr || in_data || (st_q == ST_TURN);
    frame_n_out = !(in_addr || (in_data && !(irdy_act && last)));
    irdy_oe     = in_data || (st_q == ST_TURN);
    irdy_n_out  = !irdy_act;
    ad_oe       = in_addr || (in_data && dir_wr);
    ad_out      = in_addr ? bus_addr : be_wdata;
    cbe_n_out   = in_addr ? (dir_wr ? CMD_MEM_WR : CMD_MEM_RD) : 4'b0000;
  end
endmodule

// File: rtl/dma_burst_master.sv
module dma_burst_master
  import dma_burst_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          req_n,
  input  logic          gnt_n,
  input  logic          frame_n_in,
  input  logic          irdy_n_in,
  input  logic          trdy_n,
  input  logic          stop_n,
  output logic          frame_n_out,
  output logic          frame_oe,
  output logic          irdy_n_out,
  output logic          irdy_oe,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic [3:0]    cbe_n_out,
  input  logic          be_ready,
  input  logic [AW-1:0] be_wdata,
  output logic          be_xfer,
  output logic [AW-1:0] ram_addr
);
  logic          busy, step, fin_ok, fin_abort, start_go, dir_wr, last;
  logic [AW-1:0] bus_addr;
  logic [CW-1:0] count;

  assign last    = (count == CW'(1));
  assign be_xfer = step;

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .step(step), .fin_ok(fin_ok),
    .fin_abort(fin_abort), .start_go(start_go), .bus_addr(bus_addr),
    .loc_addr(ram_addr), .count(count), .dir_wr(dir_wr), .rdata(reg_rdata)
  );

  dma_burst_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .last(last),
    .dir_wr(dir_wr), .bus_addr(bus_addr), .be_wdata(be_wdata),
    .gnt_n(gnt_n), .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in),
    .trdy_n(trdy_n), .stop_n(stop_n), .be_ready(be_ready), .busy(busy),
    .step(step), .fin_ok(fin_ok), .fin_abort(fin_abort), .req_n(req_n),
    .frame_n_out(frame_n_out), .frame_oe(frame_oe), .irdy_n_out(irdy_n_out),
    .irdy_oe(irdy_oe), .ad_out(ad_out), .ad_oe(ad_oe), .cbe_n_out(cbe_n_out)
  );
endmodule

// File: rtl/dma_burst_master_chk.sv
module dma_burst_master_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gnt_n,
  input logic          frame_n_in,
  input logic          irdy_n_in,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          req_n,
  input logic          frame_n_out,
  input logic          frame_oe,
  input logic          irdy_n_out,
  input logic          irdy_oe,
  input logic          be_xfer,
  input logic [AW-1:0] ram_addr
);
  // R2: never request and drive the bus together
  a_r2_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> !frame_oe);

  // R3: bus driving begins only after a granted, idle cycle
  a_r3_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_oe) |-> $past(!gnt_n && frame_n_in && irdy_n_in));

  // R5: each completed phase moves the local address by one word
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    be_xfer |=> (ram_addr == $past(ram_addr) + AW'(4)));

  // R6: an asserted IRDY# waits for TRDY# or STOP#
  a_r6_irdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_oe && !irdy_n_out && trdy_n && stop_n) |=> !irdy_n_out);

  // R7: FRAME# rises only alongside the final IRDY#
  a_r7_frame_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_n_out) && frame_oe && $past(stop_n)) |-> !irdy_n_out);

  // R8: turnaround cycle is followed by release
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && irdy_oe && frame_n_out && irdy_n_out) |=> (!frame_oe && !irdy_oe));
endmodule

bind dma_burst_master dma_burst_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .frame_n_in(frame_n_in),
  .irdy_n_in(irdy_n_in), .trdy_n(trdy_n), .stop_n(stop_n), .req_n(req_n),
  .frame_n_out(frame_n_out), .frame_oe(frame_oe), .irdy_n_out(irdy_n_out),
  .irdy_oe(irdy_oe), .be_xfer(be_xfer), .ram_addr(ram_addr)
);

// File: tb/dma_burst_master_tb.sv
module dma_burst_master_tb;
  localparam logic [31:0] WDATA = 32'hA5A5_3C3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_n, gnt_n = 1'b1, frame_n_in = 1'b1, irdy_n_in = 1'b1;
  logic        trdy_n = 1'b1, stop_n = 1'b1, be_ready = 1'b0;
  logic        frame_n_out, frame_oe, irdy_n_out, irdy_oe, ad_oe, be_xfer;
  logic [31:0] ad_out, ram_addr;
  logic [3:0]  cbe_n_out;

  int nchk = 0, nerr = 0;
  logic [31:0] exp_q[$];
  logic [15:0] t_mask = '0, b_mask = '1;
  int stop_at = -1;
  int pc = 0;
  bit run_dir = 0, run_abort = 0;

  always #5 clk = ~clk;

  dma_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in), .trdy_n(trdy_n),
    .stop_n(stop_n), .frame_n_out(frame_n_out), .frame_oe(frame_oe),
    .irdy_n_out(irdy_n_out), .irdy_oe(irdy_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n_out(cbe_n_out), .be_ready(be_ready), .be_wdata(WDATA),
    .be_xfer(be_xfer), .ram_addr(ram_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // target and backend model: per-cycle patterns indexed from the first data cycle
  always @(posedge clk) begin
    #1;
    if (irdy_oe) begin
      trdy_n   = (pc < 16) ? t_mask[pc] : 1'b0;
      be_ready = (pc < 16) ? b_mask[pc] : 1'b1;
      stop_n   = !(pc == stop_at);
      pc++;
    end else begin
      trdy_n = 1'b1; be_ready = 1'b0; stop_n = 1'b1; pc = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && be_xfer) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected phase", ram_addr, 32'h0);
      else begin
        logic [31:0] e;
        logic lst;
        e = exp_q.pop_front();
        chk(ram_addr == e, "R5 phase local address", ram_addr, e);
        if (run_dir) chk(ad_oe && ad_out == WDATA, "R4 write data on AD", ad_out, WDATA);
        lst = !run_abort && (exp_q.size() == 0);
        chk(frame_n_out == lst, "R7 FRAME# level on phase", {31'b0, frame_n_out}, {31'b0, lst});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic run_burst(input logic [31:0] ba, input logic [31:0] la, input logic [15:0] cnt,
                           input bit dir, input logic [15:0] tm, input logic [15:0] bm,
                           input int gdly, input int bbusy, input int stp, input int nph,
                           input bit probe);
    bit e0, e1, d0;
    logic [31:0] ectl;
    t_mask = tm; b_mask = bm; stop_at = stp; run_dir = dir; run_abort = (stp >= 0);
    for (int i = 0; i < nph; i++) exp_q.push_back(la + 32'(4 * i));
    wr(2'd0, ba);
    wr(2'd1, la);
    rd(2'd0, ba, "R1 bus address readback");
    rd(2'd1, la, "R1 local address readback");
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = {14'b0, 1'b1, dir, cnt};
    @(posedge clk); #1;
    reg_wr_en = 1'b0; #2;
    chk(req_n == 1'b0, "R2 REQ# after start", {31'b0, req_n}, 32'h0);
    for (int i = 0; i < gdly; i++) begin
      if (probe && i == 0) begin reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hDEAD_0000; end
      @(posedge clk); #1;
      reg_wr_en = 1'b0; #2;
      chk(!frame_oe, "R3 no address phase without grant", {31'b0, frame_oe}, 32'h0);
      if (probe && i == 1) rd(2'd0, ba, "R1 write ignored while busy");
    end
    gnt_n = 1'b0;
    frame_n_in = (bbusy > 0) ? 1'b0 : 1'b1;
    for (int i = 0; i < bbusy; i++) begin
      @(posedge clk); #3;
      chk(!frame_oe, "R3 no address phase on busy bus", {31'b0, frame_oe}, 32'h0);
      if (i == bbusy - 1) frame_n_in = 1'b1;
    end
    @(posedge clk); #3;
    chk(frame_oe && !frame_n_out && !irdy_oe && ad_oe, "R4 address phase controls",
        {28'b0, frame_oe, frame_n_out, irdy_oe, ad_oe}, 32'b1001);
    chk(ad_out == ba, "R4 address on AD", ad_out, ba);
    chk(cbe_n_out == (dir ? 4'b0111 : 4'b0110), "R4 command", {28'b0, cbe_n_out},
        {28'b0, (dir ? 4'b0111 : 4'b0110)});
    gnt_n = 1'b1;
    e0 = bm[0]; d0 = bm[0] && !tm[0];
    e1 = bm[1] || (bm[0] && tm[0]);
    @(posedge clk); #3;
    chk(irdy_n_out == !e0, "R6 IRDY# first data cycle", {31'b0, irdy_n_out}, {31'b0, !e0});
    if (!(d0 && cnt == 16'd1)) begin
      @(posedge clk); #3;
      chk(irdy_n_out == !e1, "R6 IRDY# second data cycle", {31'b0, irdy_n_out}, {31'b0, !e1});
    end
    for (int i = 0; i < 200 && frame_oe; i++) begin
      @(posedge clk); #3;
    end
    chk(!frame_oe && !irdy_oe && req_n, "R8 bus released", {29'b0, frame_oe, irdy_oe, req_n}, 32'b001);
    chk(exp_q.size() == 0, "R5 phase count", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    ectl = {12'b0, run_abort, !run_abort, 1'b0, dir, cnt - 16'(nph)};
    rd(2'd2, ectl, run_abort ? "R10 control after abort" : "R8 control after burst");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_n && !frame_oe && !irdy_oe && !ad_oe, "R8 reset bus idle",
        {28'b0, req_n, frame_oe, irdy_oe, ad_oe}, 32'b1000);
    rd(2'd2, 32'h0, "R2 reset control word");
    rst_n = 1'b1;
    // zero-wait write burst
    run_burst(32'h1000_0000, 32'h0000_2000, 16'd4, 1'b1, 16'h0000, 16'hFFFF, 2, 0, -1, 4, 1'b0);
    // read burst, backend late on first cycle, bus busy for two cycles
    run_burst(32'h2000_0040, 32'h0000_0100, 16'd3, 1'b0, 16'h0000, 16'hFFFE, 1, 2, -1, 3, 1'b0);
    // target wait then backend drops ready: IRDY# must hold; register lockout probe
    run_burst(32'h3000_0000, 32'h0000_0800, 16'd2, 1'b1, 16'h0001, 16'hFFFD, 3, 1, -1, 2, 1'b1);
    // STOP# on the third data cycle with the target not ready
    run_burst(32'h4000_0000, 32'h0000_1000, 16'd5, 1'b0, 16'h0004, 16'hFFFF, 1, 0, 2, 2, 1'b0);
    // single-phase burst
    run_burst(32'h5000_0000, 32'h0000_3000, 16'd1, 1'b0, 16'h0000, 16'hFFFF, 1, 0, -1, 1, 1'b0);
    // R9: done sticky across idle cycles, cleared by write-one
    repeat (3) @(posedge clk);
    #1;
    rd(2'd2, 32'h0004_0000, "R9 done still set");
    wr(2'd2, 32'h0004_0000);
    #1;
    rd(2'd2, 32'h0, "R9 done cleared");
    // R2: start with zero count is ignored
    wr(2'd2, 32'h0002_0000);
    #2;
    chk(req_n == 1'b1, "R2 zero count ignored", {31'b0, req_n}, 32'h1);
    rd(2'd2, 32'h0, "R2 zero count not busy");
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule